// File: doc/BRIEF.md
# Memory Wait-Count Scoreboard

This unit tracks, for a single wavefront, how many memory instructions are still outstanding in three classes: vector memory, export, and scalar/local-data (called LGKM below). The scheduler reports each issue together with a two-bit class code. The counters move up in the issue cycle itself. The memory pipelines later report completions and dropped instructions, and those move the counters down.

A flat-address instruction does not yet know its segment when it issues, so it is charged to both the vector and the LGKM counter. When the address is resolved, the charge for the unused segment is released.

A wait instruction loads three thresholds. An all-ones threshold means that class is ignored. The wavefront then stalls until every enabled counter is at or below its threshold. A clear operation releases the wait and returns every threshold to ignore.

All events that land on one counter in the same cycle are summed into a single net change, so none is lost. A counter that would go below zero or above its ceiling is clamped, and a sticky error flag is raised.

Top module: `waitcnt_scoreboard`

## Requirements
- R1: After reset all three counters read 0, every threshold is ignore, `wait_active` is 0, `stall` is 0 and `cnt_err` is 0.
- R2: An issue with class code 0 (vector) adds one to `vm_cnt`, code 1 (LGKM) adds one to `lgkm_cnt`, and code 3 (export) adds one to `exp_cnt`. The new count is visible on the clock edge that samples the issue.
- R3: An issue with class code 2 (flat) adds one to both `vm_cnt` and `lgkm_cnt`.
- R4: A flat resolution with `flat_res_global`=1 subtracts one from `lgkm_cnt`. With `flat_res_global`=0 it subtracts one from `vm_cnt`.
- R5: `gm_done` subtracts one from `vm_cnt`. `lm_done` and `sm_done` each subtract one from `lgkm_cnt`. `exp_done` subtracts one from `exp_cnt`.
- R6: `drop_vld` subtracts one from both `vm_cnt` and `lgkm_cnt` in one event.
- R7: All events that reach one counter in the same cycle are applied as one net change. When no event is present, every counter holds its value.
- R8: `wait_load` captures the three thresholds and sets `wait_active`. A threshold equal to all ones (2^(CNT_W+1)-1) removes its class from the check.
- R9: `stall` is 1 exactly when `wait_active` is 1 and some enabled class has its counter strictly above its threshold. A counter equal to its threshold does not stall.
- R10: `wait_clear` sets every threshold to ignore and clears `wait_active`. If `wait_load` arrives in the same cycle, the clear wins.
- R11: A net change that would take a counter below zero leaves it at 0 and sets `cnt_err`. `cnt_err` stays set until reset.
- R12: A net change that would take a counter above 2^CNT_W-1 leaves it at 2^CNT_W-1 and sets `cnt_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Scheduler issues a memory instruction this cycle |
| issue_cls | input | 2 | Class of the issued instruction: 0 vector, 1 LGKM, 2 flat, 3 export |
| gm_done | input | 1 | Global memory pipeline completes one instruction |
| lm_done | input | 1 | Local memory pipeline completes one instruction |
| sm_done | input | 1 | Scalar memory pipeline completes one instruction |
| exp_done | input | 1 | Export completes |
| drop_vld | input | 1 | Instruction with an empty execution mask is dropped |
| flat_res_vld | input | 1 | A flat instruction's segment is resolved |
| flat_res_global | input | 1 | Resolved segment: 1 global, 0 local |
| wait_load | input | 1 | Load the thresholds and enter the wait state |
| wait_clear | input | 1 | Drop the wait and reset the thresholds to ignore |
| thr_vm | input | CNT_W+1 | Vector threshold; all ones means ignore |
| thr_exp | input | CNT_W+1 | Export threshold; all ones means ignore |
| thr_lgkm | input | CNT_W+1 | LGKM threshold; all ones means ignore |
| vm_cnt | output | CNT_W | Outstanding vector memory instructions |
| exp_cnt | output | CNT_W | Outstanding export instructions |
| lgkm_cnt | output | CNT_W | Outstanding scalar/local instructions |
| wait_active | output | 1 | Wavefront is in the wait state |
| wait_met | output | 1 | Every enabled class is at or below its threshold |
| stall | output | 1 | Wavefront must not proceed |
| cnt_err | output | 1 | Sticky underflow/overflow flag |

## Verification
The bench builds the unit with CNT_W=3. The counter ceiling is then 7, so an overflow is reached after eight vector issues, and the thresholds are four bits wide with 4'b1111 as ignore. That width keeps the saturation and error paths within a few cycles of a reset. Threshold values of 0 and 2 place the counters exactly on, and one above, the comparison boundary. A same-cycle group of three LGKM decrements exercises the widest net change.

// File: rtl/wcnt_pkg.sv
package wcnt_pkg;

  typedef enum logic [1:0] {
    MC_VMEM   = 2'd0,
    MC_LGKM   = 2'd1,
    MC_FLAT   = 2'd2,
    MC_EXPORT = 2'd3
  } mem_cls_e;

  localparam int NUM_CLS = 3;
  localparam int IDX_VM  = 0;
  localparam int IDX_EXP = 1;
  localparam int IDX_LG  = 2;

  // number of asserted event bits, as a 3-bit count
  function automatic logic [2:0] ev_count(input logic [3:0] ev);
    return 3'(ev[0]) + 3'(ev[1]) + 3'(ev[2]) + 3'(ev[3]);
  endfunction

endpackage

// File: rtl/wcnt_event_map.sv
module wcnt_event_map
  import wcnt_pkg::*;
(
  input  logic       issue_vld,
  input  logic [1:0] issue_cls,
  input  logic       gm_done,
  input  logic       lm_done,
  input  logic       sm_done,
  input  logic       exp_done,
  input  logic       drop_vld,
  input  logic       flat_res_vld,
  input  logic       flat_res_global,
  output logic [NUM_CLS-1:0][2:0] inc_n,
  output logic [NUM_CLS-1:0][2:0] dec_n
);

  logic is_vm, is_lg, is_ex, flat_glb, flat_loc;

  always_comb begin
    is_vm    = issue_vld && (issue_cls == MC_VMEM || issue_cls == MC_FLAT);
    is_lg    = issue_vld && (issue_cls == MC_LGKM || issue_cls == MC_FLAT);
    is_ex    = issue_vld && (issue_cls == MC_EXPORT);
    flat_glb = flat_res_vld && flat_res_global;
    flat_loc = flat_res_vld && !flat_res_global;

    inc_n[IDX_VM]  = ev_count({3'b000, is_vm});
    inc_n[IDX_EXP] = ev_count({3'b000, is_ex});
    inc_n[IDX_LG]  = ev_count({3'b000, is_lg});

    dec_n[IDX_VM]  = ev_count({1'b0, gm_done, drop_vld, flat_loc});
    dec_n[IDX_EXP] = ev_count({3'b000, exp_done});
    dec_n[IDX_LG]  = ev_count({lm_done, sm_done, drop_vld, flat_glb});
  end

endmodule

// File: rtl/wcnt_counter.sv
module wcnt_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       inc_n,
  input  logic [2:0]       dec_n,
  output logic [CNT_W-1:0] cnt,
  output logic             under,
  output logic             over
);

  localparam int SW = CNT_W + 4;
  localparam logic signed [SW-1:0] SMAX = SW'((1 << CNT_W) - 1);

  function automatic logic signed [SW-1:0] apply_net(
    input logic [CNT_W-1:0] cur,
    input logic [2:0]       up,
    input logic [2:0]       dn
  );
    return $signed({4'b0000, cur})
         + $signed({{(SW-3){1'b0}}, up})
         - $signed({{(SW-3){1'b0}}, dn});
  endfunction

  logic signed [SW-1:0] sum;
  logic [CNT_W-1:0]     nxt;

  always_comb begin
    sum   = apply_net(cnt, inc_n, dec_n);
    under = (sum < 0);
    over  = (sum > SMAX);
    if (under)     nxt = '0;
    else if (over) nxt = '1;
    else           nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

endmodule

// File: rtl/wcnt_wait_ctl.sv
module wcnt_wait_ctl
  import wcnt_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int THR_W = CNT_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          clear,
  input  logic [NUM_CLS-1:0][THR_W-1:0] thr_in,
  input  logic [NUM_CLS-1:0][CNT_W-1:0] cnt_in,
  output logic                          waiting,
  output logic                          met
);

  localparam logic [THR_W-1:0] THR_IGNORE = '1;

  logic [NUM_CLS-1:0][THR_W-1:0] thr_q;
  logic [NUM_CLS-1:0]            cls_ok;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      thr_q   <= {NUM_CLS{THR_IGNORE}};
      waiting <= 1'b0;
    end else if (load) begin
      thr_q   <= thr_in;
      waiting <= 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cmp
    assign cls_ok[k] = (thr_q[k] == THR_IGNORE) ||
                       ({{(THR_W-CNT_W){1'b0}}, cnt_in[k]} <= thr_q[k]);
  end

  assign met = &cls_ok;

endmodule

// File: rtl/waitcnt_scoreboard.sv
module waitcnt_scoreboard
  import wcnt_pkg::*;
#(
  parameter int CNT_W = 6,
  localparam int THR_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_vld,
  input  logic [1:0]       issue_cls,
  input  logic             gm_done,
  input  logic             lm_done,
  input  logic             sm_done,
  input  logic             exp_done,
  input  logic             drop_vld,
  input  logic             flat_res_vld,
  input  logic             flat_res_global,
  input  logic             wait_load,
  input  logic             wait_clear,
  input  logic [THR_W-1:0] thr_vm,
  input  logic [THR_W-1:0] thr_exp,
  input  logic [THR_W-1:0] thr_lgkm,
  output logic [CNT_W-1:0] vm_cnt,
  output logic [CNT_W-1:0] exp_cnt,
  output logic [CNT_W-1:0] lgkm_cnt,
  output logic             wait_active,
  output logic             wait_met,
  output logic             stall,
  output logic             cnt_err
);

  logic [NUM_CLS-1:0][2:0]       inc_n;
  logic [NUM_CLS-1:0][2:0]       dec_n;
  logic [NUM_CLS-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CLS-1:0]            under_v;
  logic [NUM_CLS-1:0]            over_v;
  logic                          any_under;
  logic                          any_over;

  wcnt_event_map u_map (
    .issue_vld       (issue_vld),
    .issue_cls       (issue_cls),
    .gm_done         (gm_done),
    .lm_done         (lm_done),
    .sm_done         (sm_done),
    .exp_done        (exp_done),
    .drop_vld        (drop_vld),
    .flat_res_vld    (flat_res_vld),
    .flat_res_global (flat_res_global),
    .inc_n           (inc_n),
    .dec_n           (dec_n)
  );

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cnt
    wcnt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_n (inc_n[k]),
      .dec_n (dec_n[k]),
      .cnt   (cnt_all[k]),
      .under (under_v[k]),
      .over  (over_v[k])
    );
  end

  assign vm_cnt    = cnt_all[IDX_VM];
  assign exp_cnt   = cnt_all[IDX_EXP];
  assign lgkm_cnt  = cnt_all[IDX_LG];
  assign any_under = |under_v;
  assign any_over  = |over_v;

  wcnt_wait_ctl #(.CNT_W(CNT_W), .THR_W(THR_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wait_load),
    .clear   (wait_clear),
    .thr_in  ({thr_lgkm, thr_exp, thr_vm}),
    .cnt_in  (cnt_all),
    .waiting (wait_active),
    .met     (wait_met)
  );

  assign stall = wait_active && !wait_met;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_err <= 1'b0;
    else        cnt_err <= cnt_err | any_under | any_over;
  end

endmodule

// File: rtl/wcnt_checks.sv
module wcnt_checks #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_vld,
  input logic [1:0]       issue_cls,
  input logic             gm_done,
  input logic             lm_done,
  input logic             sm_done,
  input logic             exp_done,
  input logic             drop_vld,
  input logic             flat_res_vld,
  input logic             flat_res_global,
  input logic             wait_load,
  input logic             wait_clear,
  input logic [CNT_W-1:0] vm_cnt,
  input logic [CNT_W-1:0] exp_cnt,
  input logic [CNT_W-1:0] lgkm_cnt,
  input logic             wait_active,
  input logic             wait_met,
  input logic             stall,
  input logic             cnt_err,
  input logic             any_under,
  input logic             any_over
);

  logic vm_dec_any, lg_dec_any, quiet;
  assign vm_dec_any = gm_done || drop_vld || (flat_res_vld && !flat_res_global);
  assign lg_dec_any = lm_done || sm_done || drop_vld || (flat_res_vld && flat_res_global);
  assign quiet = !issue_vld && !gm_done && !lm_done && !sm_done && !exp_done &&
                 !drop_vld && !flat_res_vld;

  AST_VM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && issue_cls == 2'd0 && !vm_dec_any && vm_cnt != '1
    |=> vm_cnt == CNT_W'($past(vm_cnt) + 1'b1)); // R2

  AST_FLAT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && issue_cls == 2'd2 && !vm_dec_any && !lg_dec_any &&
    vm_cnt != '1 && lgkm_cnt != '1
    |=> vm_cnt == CNT_W'($past(vm_cnt) + 1'b1) &&
        lgkm_cnt == CNT_W'($past(lgkm_cnt) + 1'b1)); // R3

  AST_DROP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    drop_vld && !issue_vld && !gm_done && !lm_done && !sm_done && !flat_res_vld &&
    vm_cnt != '0 && lgkm_cnt != '0
    |=> vm_cnt == CNT_W'($past(vm_cnt) - 1'b1) &&
        lgkm_cnt == CNT_W'($past(lgkm_cnt) - 1'b1)); // R6

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(vm_cnt) && $stable(exp_cnt) && $stable(lgkm_cnt)); // R7

  AST_LOAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_load && !wait_clear |=> wait_active); // R8

  AST_NO_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_active |-> !stall); // R9

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wait_clear |=> !wait_active && wait_met && !stall); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |=> cnt_err); // R11

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    any_under |=> cnt_err); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    any_over |=> cnt_err); // R12

endmodule

bind waitcnt_scoreboard wcnt_checks #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/waitcnt_scoreboard_test.sv
`timescale 1ns/1ps
module waitcnt_scoreboard_test;

  localparam int CW = 3;
  localparam int TW = CW + 1;
  localparam logic [TW-1:0] IGN = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic issue_vld, gm_done, lm_done, sm_done, exp_done, drop_vld;
  logic flat_res_vld, flat_res_global, wait_load, wait_clear;
  logic [1:0] issue_cls;
  logic [TW-1:0] thr_vm, thr_exp, thr_lgkm;
  logic [CW-1:0] vm_cnt, exp_cnt, lgkm_cnt;
  logic wait_active, wait_met, stall, cnt_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  waitcnt_scoreboard #(.CNT_W(CW)) uut (.*);

  // {issue, cls, gm lm sm ex dr frv frg, exp vm, exp ex, exp lg}
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd0, 7'b0000000, 3'd1, 3'd0, 3'd0}, // R2 vector issue
    {1'b1, 2'd1, 7'b0000000, 3'd1, 3'd0, 3'd1}, // R2 lgkm issue
    {1'b1, 2'd3, 7'b0000000, 3'd1, 3'd1, 3'd1}, // R2 export issue
    {1'b1, 2'd2, 7'b0000000, 3'd2, 3'd1, 3'd2}, // R3 flat issue
    {1'b0, 2'd0, 7'b0000011, 3'd2, 3'd1, 3'd1}, // R4 flat -> global
    {1'b1, 2'd2, 7'b0000000, 3'd3, 3'd1, 3'd2}, // R3
    {1'b0, 2'd0, 7'b0000010, 3'd2, 3'd1, 3'd2}, // R4 flat -> local
    {1'b0, 2'd0, 7'b1000000, 3'd1, 3'd1, 3'd2}, // R5 gm
    {1'b0, 2'd0, 7'b0110000, 3'd1, 3'd1, 3'd0}, // R5 lm+sm, R7
    {1'b0, 2'd0, 7'b0001000, 3'd1, 3'd0, 3'd0}, // R5 export done
    {1'b1, 2'd2, 7'b0000100, 3'd1, 3'd0, 3'd0}, // R7 flat + drop
    {1'b1, 2'd0, 7'b1000000, 3'd1, 3'd0, 3'd0}, // R7 net zero
    {1'b1, 2'd1, 7'b0000000, 3'd1, 3'd0, 3'd1}, // R2
    {1'b0, 2'd0, 7'b0000100, 3'd0, 3'd0, 3'd0}, // R6 drop
    {1'b1, 2'd2, 7'b0000000, 3'd1, 3'd0, 3'd1}, // R3
    {1'b1, 2'd1, 7'b0000000, 3'd1, 3'd0, 3'd2}, // R2
    {1'b1, 2'd1, 7'b0000000, 3'd1, 3'd0, 3'd3}, // R2
    {1'b0, 2'd0, 7'b0110100, 3'd0, 3'd0, 3'd0}  // R7 three lgkm decs
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    issue_vld = 0; issue_cls = 2'd0; gm_done = 0; lm_done = 0; sm_done = 0;
    exp_done = 0; drop_vld = 0; flat_res_vld = 0; flat_res_global = 0;
    wait_load = 0; wait_clear = 0; thr_vm = IGN; thr_exp = IGN; thr_lgkm = IGN;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] c);
    issue_vld = 1; issue_cls = c;
    step();
  endtask

  task automatic check_reset_state();
    chk("R1 vm_cnt", vm_cnt, 0);
    chk("R1 exp_cnt", exp_cnt, 0);
    chk("R1 lgkm_cnt", lgkm_cnt, 0);
    chk("R1 wait_active", wait_active, 0);
    chk("R1 stall", stall, 0);
    chk("R1 wait_met", wait_met, 1);
    chk("R1 cnt_err", cnt_err, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    check_reset_state();

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      issue_vld = v[18]; issue_cls = v[17:16];
      gm_done = v[15]; lm_done = v[14]; sm_done = v[13]; exp_done = v[12];
      drop_vld = v[11]; flat_res_vld = v[10]; flat_res_global = v[9];
      step();
      chk($sformatf("R2/R3/R4/R5/R6/R7 row %0d vm", i), vm_cnt, int'(v[8:6]));
      chk($sformatf("R2/R3/R4/R5/R6/R7 row %0d exp", i), exp_cnt, int'(v[5:3]));
      chk($sformatf("R2/R3/R4/R5/R6/R7 row %0d lgkm", i), lgkm_cnt, int'(v[2:0]));
    end
    chk("R11 no error in table", cnt_err, 0);

    // quiet cycles hold: R7
    step(); step();
    chk("R7 hold vm", vm_cnt, 0);

    // wait: vm<=2, export ignored, lgkm<=0
    wait_load = 1; thr_vm = 4'd2; thr_exp = IGN; thr_lgkm = 4'd0;
    step();
    chk("R8 wait_active after load", wait_active, 1);
    chk("R9 no stall at zero", stall, 0);
    issue(2'd3); issue(2'd3);
    chk("R8 export ignored exp_cnt", exp_cnt, 2);
    chk("R8 export ignored stall", stall, 0);
    issue(2'd0); issue(2'd0);
    chk("R9 equal threshold no stall", stall, 0);
    issue(2'd0);
    chk("R9 above threshold stall", stall, 1);
    chk("R9 wait_met low", wait_met, 0);
    gm_done = 1; step();
    chk("R9 back to threshold", stall, 0);
    issue(2'd1);
    chk("R9 lgkm above zero stall", stall, 1);
    lm_done = 1; step();
    chk("R9 lgkm back to zero", stall, 0);

    // clear wins over load: R10
    wait_load = 1; wait_clear = 1; thr_vm = 4'd0; thr_exp = 4'd0; thr_lgkm = 4'd0;
    step();
    chk("R10 clear wins wait_active", wait_active, 0);
    chk("R10 clear wins stall", stall, 0);
    wait_load = 1; thr_vm = 4'd0;
    step();
    chk("R8 load vm=0 stalls", stall, 1);
    wait_clear = 1;
    step();
    chk("R10 clear wait_active", wait_active, 0);
    chk("R10 clear stall", stall, 0);
    chk("R10 thresholds ignore", wait_met, 1);
    wait_load = 1;
    step();
    chk("R8 all-ignore load active", wait_active, 1);
    chk("R8 all-ignore no stall", stall, 0);

    // reset mid-run: R1
    do_reset();
    check_reset_state();

    // overflow: R12
    for (int i = 0; i < 7; i++) issue(2'd0);
    chk("R12 at ceiling", vm_cnt, 7);
    chk("R12 no error at ceiling", cnt_err, 0);
    issue(2'd0);
    chk("R12 saturated", vm_cnt, 7);
    chk("R12 error set", cnt_err, 1);

    // underflow: R11
    do_reset();
    gm_done = 1; step();
    chk("R11 clamped at zero", vm_cnt, 0);
    chk("R11 error set", cnt_err, 1);
    issue(2'd1);
    chk("R11 counter still works", lgkm_cnt, 1);
    chk("R11 error sticky", cnt_err, 1);

    finish_run();
  end

endmodule